// File: doc/BRIEF.md
# Adaptive Background-Model Pixel Classifier

This block classifies a stream of monochrome pixels as scene background or moving foreground, one pixel per clock. Alongside each greyscale sample it receives the running mean and variance held for that pixel's location. It returns a single mask bit, plus a refreshed mean and variance that the surrounding logic writes back to statistics storage at the address that travels with the result.

Each location is modelled by one Gaussian. The block does not evaluate a density. It compares the squared deviation of the sample from the mean with a fixed multiple of the variance. A background sample pulls the model toward itself through an exponential blend set by a learning weight. A foreground sample leaves the mean alone and replaces the variance with a default. Both written-back values are confined to configured windows. All arithmetic is integer; there is no division and no exponent.

The work is split over four register stages, so four pixels are in flight at once. A valid flag and the pixel address ride along with the data.

Top module: `bgm_pixel_pipe`

## Requirements
- R1: A valid sample is background (`out_fg`=0) when d² ≤ 2·v + floor(v/2), where d = x − mean and v is the input variance. Otherwise it is foreground (`out_fg`=1). Equality counts as background.
- R2: For a background sample the new mean is floor((A·mean + (256−A)·x)/256), where A is the 8-bit learning weight `ALPHA` (default 224).
- R3: For a background sample the new variance is floor((A·v + (256−A)·d²)/256).
- R4: For a foreground sample the mean passes through unchanged and the variance becomes `VAR_DEFAULT` (default 900).
- R5: The mean written back is clamped into [`MEAN_MIN`, `MEAN_MAX`] (default 4..250). The variance is clamped into [`VAR_MIN`, `VAR_MAX`] (default 16..20000). Clamping applies after the update or replacement.
- R6: Results appear exactly four clock edges after the input is sampled. A new pixel is accepted on every clock with no gaps.
- R7: `out_addr` equals the `in_addr` that was sampled with the same pixel.
- R8: A synchronous active-high reset clears the pipeline. `out_valid`, `out_fg`, `out_mean` and `out_var` read 0 after it, and a pixel presented during a reset cycle never emerges.
- R9: A cycle with `in_valid` low gives a cycle with `out_valid` low four edges later, without disturbing neighbouring pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is meaningful this cycle |
| in_addr | input | 10 | Location of the sample in statistics storage |
| in_pix | input | 8 | Greyscale sample x |
| in_mean | input | 8 | Stored mean for this location |
| in_var | input | 16 | Stored variance for this location |
| out_valid | output | 1 | Result is meaningful this cycle |
| out_addr | output | 10 | Write-back location |
| out_fg | output | 1 | 1 = foreground, 0 = background |
| out_mean | output | 8 | Updated, clamped mean |
| out_var | output | 16 | Updated, clamped variance |

## Verification
The hardest case to reach is the exact decision boundary, where the squared deviation equals the scaled variance. A single step of the comparison or of the floor in the half-variance term flips the class there. The vector table aims directly at it: it pairs variances that are multiples of two with deviations of equal squared magnitude, approached from both signs of the difference, and then steps one grey level beyond. Clamp edges are reached in the same way. Stored means and variances are chosen so that the truncated blend lands just outside a window bound.

// File: rtl/bgm_pkg.sv
package bgm_pkg;

    localparam int PIX_W  = 8;
    localparam int VAR_W  = 16;
    localparam int ADDR_W = 10;
    localparam int FRAC_W = 8;

    localparam int DIFF_W = PIX_W + 1;
    localparam int SQ_W   = 2 * PIX_W;
    localparam int KVAR_W = VAR_W + 2;
    localparam int MIX_W  = ((VAR_W > SQ_W) ? VAR_W : SQ_W) + FRAC_W + 1;
    localparam int BL_W   = MIX_W + FRAC_W + 1;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [VAR_W-1:0]  var_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SQ_W-1:0]   sq_t;
    typedef logic [KVAR_W-1:0] kvar_t;
    typedef logic [MIX_W-1:0]  mix_t;
    typedef logic [FRAC_W-1:0] wt_t;

    // after stage 1: signed deviation and blended mean
    typedef struct packed {
        logic                     valid;
        addr_t                    addr;
        logic signed [DIFF_W-1:0] diff;
        pix_t                     mean_old;
        pix_t                     mean_new;
        var_t                     var_old;
    } st1_t;

    // after stage 2: squared deviation and scaled variance
    typedef struct packed {
        logic  valid;
        addr_t addr;
        sq_t   sq;
        kvar_t kvar;
        pix_t  mean_old;
        pix_t  mean_new;
        var_t  var_old;
    } st2_t;

    // after stage 3: class decided, variance not yet bounded
    typedef struct packed {
        logic  valid;
        addr_t addr;
        logic  fg;
        pix_t  mean_sel;
        mix_t  var_raw;
    } st3_t;

    // after stage 4: final write-back record
    typedef struct packed {
        logic  valid;
        addr_t addr;
        logic  fg;
        pix_t  mean;
        var_t  vr;
    } st4_t;

    // floor((a*old + (2^FRAC_W - a)*new) / 2^FRAC_W)
    function automatic mix_t blend(mix_t old_v, mix_t new_v, wt_t a);
        logic [BL_W-1:0] wo, wn, wa, wb, acc;
        wo  = BL_W'(old_v);
        wn  = BL_W'(new_v);
        wa  = BL_W'(a);
        wb  = BL_W'(1 << FRAC_W) - wa;
        acc = wo * wa + wn * wb;
        return MIX_W'(acc >> FRAC_W);
    endfunction

    function automatic mix_t clamp_mix(mix_t v, mix_t lo, mix_t hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/bgm_front.sv
module bgm_front
    import bgm_pkg::*;
#(
    parameter wt_t ALPHA = 8'd224
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  addr_t in_addr,
    input  pix_t  in_pix,
    input  pix_t  in_mean,
    input  var_t  in_var,
    output st2_t  s2_q
);

    st1_t s1_d, s1_q;
    st2_t s2_d;
    pix_t mag;

    // stage 1: deviation and mean blend
    always_comb begin
        s1_d.valid    = in_valid;
        s1_d.addr     = in_addr;
        s1_d.diff     = $signed({1'b0, in_pix}) - $signed({1'b0, in_mean});
        s1_d.mean_old = in_mean;
        s1_d.mean_new = PIX_W'(blend(MIX_W'(in_mean), MIX_W'(in_pix), ALPHA));
        s1_d.var_old  = in_var;
    end

    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= s1_d;
    end

    // stage 2: square of deviation, 2.5 times variance
    always_comb begin
        mag = s1_q.diff[DIFF_W-1] ? PIX_W'(-s1_q.diff) : PIX_W'(s1_q.diff);
        s2_d.valid    = s1_q.valid;
        s2_d.addr     = s1_q.addr;
        s2_d.sq       = SQ_W'(mag) * SQ_W'(mag);
        s2_d.kvar     = (KVAR_W'(s1_q.var_old) << 1) + KVAR_W'(s1_q.var_old >> 1);
        s2_d.mean_old = s1_q.mean_old;
        s2_d.mean_new = s1_q.mean_new;
        s2_d.var_old  = s1_q.var_old;
    end

    always_ff @(posedge clk) begin
        if (rst) s2_q <= '0;
        else     s2_q <= s2_d;
    end

    // R2: a blend never leaves the span of its two operands
    assert_mean_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        s1_q.valid |->
            ((s1_q.mean_new >= s1_q.mean_old) || (s1_q.mean_new >= $past(in_pix))) &&
            ((s1_q.mean_new <= s1_q.mean_old) || (s1_q.mean_new <= $past(in_pix))));

endmodule

// File: rtl/bgm_decide.sv
module bgm_decide
    import bgm_pkg::*;
#(
    parameter wt_t  ALPHA       = 8'd224,
    parameter var_t VAR_DEFAULT = 16'd900
) (
    input  logic clk,
    input  logic rst,
    input  st2_t s2,
    output st3_t s3_q
);

    st3_t s3_d;
    logic is_fg;

    // stage 3: compare, select mean, update or replace variance
    always_comb begin
        is_fg         = KVAR_W'(s2.sq) > s2.kvar;
        s3_d.valid    = s2.valid;
        s3_d.addr     = s2.addr;
        s3_d.fg       = is_fg;
        s3_d.mean_sel = is_fg ? s2.mean_old : s2.mean_new;
        s3_d.var_raw  = is_fg ? MIX_W'(VAR_DEFAULT)
                              : blend(MIX_W'(s2.var_old), MIX_W'(s2.sq), ALPHA);
    end

    always_ff @(posedge clk) begin
        if (rst) s3_q <= '0;
        else     s3_q <= s3_d;
    end

    // R3: background variance stays within the span of old variance and square
    assert_var_blend_span_R3: assert property (@(posedge clk) disable iff (rst)
        (s3_q.valid && !s3_q.fg) |->
            ((s3_q.var_raw <= MIX_W'($past(s2.var_old))) ||
             (s3_q.var_raw <= MIX_W'($past(s2.sq)))));

endmodule

// File: rtl/bgm_clamp.sv
module bgm_clamp
    import bgm_pkg::*;
#(
    parameter pix_t MEAN_MIN = 8'd4,
    parameter pix_t MEAN_MAX = 8'd250,
    parameter var_t VAR_MIN  = 16'd16,
    parameter var_t VAR_MAX  = 16'd20000
) (
    input  logic clk,
    input  logic rst,
    input  st3_t s3,
    output st4_t s4_q
);

    st4_t s4_d;

    // stage 4: bound both statistics
    always_comb begin
        s4_d.valid = s3.valid;
        s4_d.addr  = s3.addr;
        s4_d.fg    = s3.fg;
        s4_d.mean  = PIX_W'(clamp_mix(MIX_W'(s3.mean_sel), MIX_W'(MEAN_MIN), MIX_W'(MEAN_MAX)));
        s4_d.vr    = VAR_W'(clamp_mix(s3.var_raw, MIX_W'(VAR_MIN), MIX_W'(VAR_MAX)));
    end

    always_ff @(posedge clk) begin
        if (rst) s4_q <= '0;
        else     s4_q <= s4_d;
    end

    // R5: an in-window variance passes the bounding stage untouched
    assert_var_passthrough_R5: assert property (@(posedge clk) disable iff (rst)
        (s4_q.valid && ($past(s3.var_raw) >= MIX_W'(VAR_MIN)) &&
         ($past(s3.var_raw) <= MIX_W'(VAR_MAX)))
            |-> (MIX_W'(s4_q.vr) == $past(s3.var_raw)));

endmodule

// File: rtl/bgm_pixel_pipe.sv
module bgm_pixel_pipe
    import bgm_pkg::*;
#(
    parameter wt_t  ALPHA       = 8'd224,
    parameter var_t VAR_DEFAULT = 16'd900,
    parameter pix_t MEAN_MIN    = 8'd4,
    parameter pix_t MEAN_MAX    = 8'd250,
    parameter var_t VAR_MIN     = 16'd16,
    parameter var_t VAR_MAX     = 16'd20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic [PIX_W-1:0]  in_mean,
    input  logic [VAR_W-1:0]  in_var,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_fg,
    output logic [PIX_W-1:0]  out_mean,
    output logic [VAR_W-1:0]  out_var
);

    localparam int DEPTH = 4;

    st2_t s2;
    st3_t s3;
    st4_t s4;

    bgm_front #(.ALPHA(ALPHA)) u_front (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .in_pix(in_pix), .in_mean(in_mean), .in_var(in_var), .s2_q(s2)
    );

    bgm_decide #(.ALPHA(ALPHA), .VAR_DEFAULT(VAR_DEFAULT)) u_decide (
        .clk(clk), .rst(rst), .s2(s2), .s3_q(s3)
    );

    bgm_clamp #(
        .MEAN_MIN(MEAN_MIN), .MEAN_MAX(MEAN_MAX),
        .VAR_MIN(VAR_MIN),   .VAR_MAX(VAR_MAX)
    ) u_clamp (
        .clk(clk), .rst(rst), .s3(s3), .s4_q(s4)
    );

    assign out_valid = s4.valid;
    assign out_addr  = s4.addr;
    assign out_fg    = s4.fg;
    assign out_mean  = s4.mean;
    assign out_var   = s4.vr;

    // cycles since reset, saturating; gates the latency checks
    logic [2:0] warm;
    always_ff @(posedge clk) begin
        if (rst)                    warm <= '0;
        else if (warm < 3'(DEPTH))  warm <= warm + 3'd1;
    end

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (warm == 3'(DEPTH)) |-> (out_valid == $past(in_valid, 4)));

    assert_addr_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (warm == 3'(DEPTH) && out_valid) |-> (out_addr == $past(in_addr, 4)));

    assert_fg_var_default_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fg) |->
            (MIX_W'(out_var) == clamp_mix(MIX_W'(VAR_DEFAULT), MIX_W'(VAR_MIN), MIX_W'(VAR_MAX))));

    assert_fg_mean_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (warm == 3'(DEPTH) && out_valid && out_fg &&
         $past(in_mean, 4) >= MEAN_MIN && $past(in_mean, 4) <= MEAN_MAX)
            |-> (out_mean == $past(in_mean, 4)));

endmodule

// File: tb/tb_bgm_pixel_pipe.sv
`timescale 1ns/1ps
module tb_bgm_pixel_pipe;

    localparam int A    = 224;
    localparam int VDEF = 900;
    localparam int MMIN = 4,  MMAX = 250;
    localparam int VMIN = 16, VMAX = 20000;
    localparam int NV   = 10;

    // {x, mean, var, expected fg}
    localparam logic [32:0] VEC [NV] = '{
        {8'd100, 8'd100, 16'd100,   1'b0},
        {8'd110, 8'd100, 16'd40,    1'b0},
        {8'd111, 8'd100, 16'd40,    1'b1},
        {8'd90,  8'd100, 16'd40,    1'b0},
        {8'd0,   8'd4,   16'd16,    1'b0},
        {8'd255, 8'd255, 16'd16,    1'b0},
        {8'd255, 8'd0,   16'd20000, 1'b1},
        {8'd200, 8'd10,  16'd20000, 1'b0},
        {8'd50,  8'd60,  16'd1000,  1'b0},
        {8'd0,   8'd250, 16'd30,    1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [9:0]  in_addr = '0;
    logic [7:0]  in_pix = '0, in_mean = '0;
    logic [15:0] in_var = '0;
    logic        out_valid, out_fg;
    logic [9:0]  out_addr;
    logic [7:0]  out_mean;
    logic [15:0] out_var;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bgm_pixel_pipe dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .in_pix(in_pix), .in_mean(in_mean), .in_var(in_var),
        .out_valid(out_valid), .out_addr(out_addr), .out_fg(out_fg),
        .out_mean(out_mean), .out_var(out_var)
    );

    function automatic int lim(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int sqdev(int x, int m);
        return (x - m) * (x - m);
    endfunction

    function automatic int ref_fg(int x, int m, int v);
        return (sqdev(x, m) > 2 * v + v / 2) ? 1 : 0;
    endfunction

    function automatic int ref_mean(int x, int m, int v);
        if (ref_fg(x, m, v) == 1) return lim(m, MMIN, MMAX);
        return lim((A * m + (256 - A) * x) / 256, MMIN, MMAX);
    endfunction

    function automatic int ref_var(int x, int m, int v);
        if (ref_fg(x, m, v) == 1) return lim(VDEF, VMIN, VMAX);
        return lim((A * v + (256 - A) * sqdev(x, m)) / 256, VMIN, VMAX);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(bit v, int a, int x, int m, int vr);
        in_valid = v;
        in_addr  = 10'(a);
        in_pix   = 8'(x);
        in_mean  = 8'(m);
        in_var   = 16'(vr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: cleared outputs after reset
        chk("R8 valid after reset", int'(out_valid), 0);
        chk("R8 fg after reset", int'(out_fg), 0);
        chk("R8 mean after reset", int'(out_mean), 0);
        chk("R8 var after reset", int'(out_var), 0);

        // table walk, back-to-back pixels
        for (int c = 0; c < NV + 4; c++) begin
            @(negedge clk);
            if (c >= 4) begin
                automatic int k = c - 4;
                automatic int x = int'(VEC[k][32:25]);
                automatic int m = int'(VEC[k][24:17]);
                automatic int v = int'(VEC[k][16:1]);
                chk("R6 valid at latency 4", int'(out_valid), 1);
                chk("R7 address follows", int'(out_addr), k);
                chk("R1 class", int'(out_fg), int'(VEC[k][0]));
                chk("R1 class model", int'(out_fg), ref_fg(x, m, v));
                chk("R2/R4/R5 mean", int'(out_mean), ref_mean(x, m, v));
                chk("R3/R4/R5 var", int'(out_var), ref_var(x, m, v));
            end
            if (c < NV)
                drive(1'b1, c, int'(VEC[c][32:25]), int'(VEC[c][24:17]), int'(VEC[c][16:1]));
            else
                drive(1'b0, 0, 0, 0, 0);
        end

        // R5 hand values: truncated mean 3 lifts to 4, 255 drops to 250, var 22012 to 20000
        chk("R5 hand low mean", ref_mean(0, 4, 16), 4);
        chk("R5 hand high mean", ref_mean(255, 255, 16), 250);
        chk("R5 hand var cap", ref_var(200, 10, 20000), 20000);

        // R9: bubbles on odd cycles
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (c >= 4) begin
                automatic int k = c - 4;
                chk("R9 bubble valid", int'(out_valid), (k % 2 == 0 && k < 8) ? 1 : 0);
                if (k % 2 == 0 && k < 8) chk("R9 bubble addr", int'(out_addr), 100 + k);
            end
            drive(c < 8 && c % 2 == 0, 100 + c, 50, 50, 100);
        end

        // R8: reset mid-stream drops in-flight and reset-cycle pixels
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            drive(1'b1, 200 + c, 60, 60, 100);
        end
        @(negedge clk);
        rst = 1'b1;
        drive(1'b1, 300, 60, 60, 100);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 0, 0, 0, 0);
        for (int c = 0; c < 5; c++) begin
            chk("R8 flushed by reset", int'(out_valid), 0);
            @(negedge clk);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule